// File: doc/BRIEF.md
# Permission-Gated Clock Shutdown Controller

This block decides when a clock domain, a clock source or the flash power state may really turn off once software has asked for it. Software holds one disable bit for each domain and one for each source. It also sets a two-bit source selection for each domain and a fall-back mode field for each flash bank and for the flash pump. The block turns these requests into enables for the gating cells, the oscillators and the flash. It switches something off only after everything that depends on it has let go.

A domain stops only when its disable bit is set and every module it feeds grants permission. The CPU domain (index 0) also needs the core's idle indication. Permission and idle inputs are asynchronous and pass through a two-flop synchronizer. A source stops only when its disable bit is set and no enabled domain selects it. When a disable bit is cleared, the domain runs again at the next edge, and so does the source it selects. Each bank sleeps when its field selects sleep. The pump sleeps only when its own field selects sleep and every bank is already asleep. Software reads `dom_clk_en` and `src_en` as the actual state and polls them until the shutdown is complete. There is no data stream, so every pin is plain control or status.

Top module: `clk_shutdown_ctrl`

## Requirements
- R1: A domain's `dom_clk_en` bit falls only when its `dom_off_req` bit is set and all N_MOD synchronized grants of that domain are 1. Grants for domain d are `mod_grant[d*N_MOD +: N_MOD]`.
- R2: A source's `src_en` bit stays 1 while any domain with `dom_clk_en`=1 selects it. The selection for domain d is `dom_src_sel[d*2 +: 2]`. The source falls one edge after the last such domain stops or moves away, and only if its `src_off_req` bit is set.
- R3: Domain 0 (the CPU domain) additionally needs the synchronized `cpu_idle` to be 1 before it stops.
- R4: `pump_sleep` is 1 only while every `bank_sleep` bit is 1. When a bank leaves sleep, `pump_sleep` falls on the same edge.
- R5: Mode fields use the encoding 2'b00 = sleep, 2'b01 = standby and 2'b11 = active. Bank b is `bank_mode[b*2 +: 2]`. `bank_sleep[b]` is registered as (field == sleep), and `pump_sleep` needs `pump_mode` == sleep.
- R6: Clearing a `dom_off_req` bit sets that domain's `dom_clk_en` bit on the next edge, with no regard to grants. It also sets `src_en` for the source that domain selects on the same edge.
- R7: A domain that has stopped stays stopped while its request is held, even if its grants are withdrawn.
- R8: During reset and right after it, every domain and every source is enabled, and no bank or the pump is asleep.
- R9: A grant or idle change reaches the gating decision through two flops: the domain stops on the third rising edge after the input settles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dom_off_req | input | N_DOM | Software disable request for each domain |
| src_off_req | input | N_SRC | Software disable request for each source |
| dom_src_sel | input | N_DOM*2 | Two-bit source selection for each domain |
| mod_grant | input | N_DOM*N_MOD | Asynchronous permission-to-stop from the modules, grouped by domain |
| cpu_idle | input | 1 | Asynchronous indication that the core has drained |
| bank_mode | input | N_BANK*2 | Fall-back mode field for each flash bank |
| pump_mode | input | 2 | Fall-back mode field for the flash pump |
| dom_clk_en | output | N_DOM | Actual clock enable for each domain (status) |
| src_en | output | N_SRC | Actual enable for each source (status) |
| bank_sleep | output | N_BANK | Flash bank is put to sleep |
| pump_sleep | output | 1 | Flash pump is put to sleep |

## Verification
The bench targets these corner cases:

- **Partial grant.** Only seven of a domain's eight modules grant permission. A design that checks any bit instead of all bits would stop the clock.
- **Grants withdrawn.** A domain that has already stopped loses its grants. A design that re-evaluates the grants would wake the domain.
- **Source still in use.** A source is requested off while a running domain still selects it, or a domain is moved onto a source that is off. A wrong design would kill the clock that domain runs on.
- **CPU domain without idle.** Every grant is present but the core is not idle. A wrong design would stop the CPU domain.
- **Synchronizer latency.** The bench samples on each edge around the two-flop window, which exposes a missing or an extra synchronizer stage.
- **Pump versus banks.** One bank stays out of sleep, or a bank wakes. A wrong design would leave the pump asleep under an active bank.

// File: rtl/csc_pkg.sv
package csc_pkg;

  localparam int unsigned CSC_SEL_W = 2;

  typedef enum logic [1:0] {
    FM_SLEEP   = 2'b00,
    FM_STANDBY = 2'b01,
    FM_ACTIVE  = 2'b11
  } flash_mode_e;

  function automatic logic is_sleep(input logic [1:0] field);
    return field == FM_SLEEP;
  endfunction

endpackage

// File: rtl/csc_sync.sv
module csc_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign q_sync = sync_q;
endmodule

// File: rtl/csc_domain_gate.sv
module csc_domain_gate #(
  parameter int unsigned N_MOD  = 8,
  parameter bit          IS_CPU = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             off_req,
  input  logic [N_MOD-1:0] grants_s,
  input  logic             idle_s,
  output logic             en
);
  logic en_q;
  logic all_granted;
  logic core_ready;
  logic stop_now;

  assign all_granted = &grants_s;
  assign core_ready  = IS_CPU ? idle_s : 1'b1;
  assign stop_now    = en_q && off_req && all_granted && core_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= 1'b1;
    else if (!off_req) en_q <= 1'b1;
    else if (stop_now) en_q <= 1'b0;
  end

  assign en = en_q;
endmodule

// File: rtl/csc_source_ctrl.sv
module csc_source_ctrl #(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned N_DOM = 6,
  parameter int unsigned SEL_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_DOM-1:0]       dom_en,
  input  logic [N_DOM-1:0]       dom_off_req,
  input  logic [N_DOM*SEL_W-1:0] dom_src_sel,
  input  logic [N_SRC-1:0]       src_off_req,
  output logic [N_SRC-1:0]       src_en
);
  logic [N_SRC-1:0] needed;
  logic [N_SRC-1:0] src_en_q;

  always_comb begin
    needed = '0;
    for (int s = 0; s < N_SRC; s++) begin
      for (int d = 0; d < N_DOM; d++) begin
        if (dom_src_sel[d*SEL_W +: SEL_W] == SEL_W'(s) && (dom_en[d] || !dom_off_req[d]))
          needed[s] = 1'b1;
      end
    end
  end

  genvar gs;
  generate
    for (gs = 0; gs < N_SRC; gs++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_en_q[gs] <= 1'b1;
        else        src_en_q[gs] <= needed[gs] || !src_off_req[gs];
      end
    end
  endgenerate

  assign src_en = src_en_q;
endmodule

// File: rtl/csc_flash_seq.sv
module csc_flash_seq
  import csc_pkg::*;
#(
  parameter int unsigned N_BANK = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_BANK*2-1:0] bank_mode,
  input  logic [1:0]          pump_mode,
  output logic [N_BANK-1:0]   bank_sleep,
  output logic                pump_sleep
);
  logic [N_BANK-1:0] bank_d;
  logic [N_BANK-1:0] bank_q;
  logic              pump_q;

  genvar gb;
  generate
    for (gb = 0; gb < N_BANK; gb++) begin : g_bank
      assign bank_d[gb] = is_sleep(bank_mode[gb*2 +: 2]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      pump_q <= 1'b0;
    end else begin
      bank_q <= bank_d;
      pump_q <= is_sleep(pump_mode) && (&bank_q) && (&bank_d);
    end
  end

  assign bank_sleep = bank_q;
  assign pump_sleep = pump_q;
endmodule

// File: rtl/clk_shutdown_ctrl.sv
module clk_shutdown_ctrl
  import csc_pkg::*;
#(
  parameter int unsigned N_SRC  = 4,
  parameter int unsigned N_DOM  = 6,
  parameter int unsigned N_MOD  = 8,
  parameter int unsigned N_BANK = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_DOM-1:0]           dom_off_req,
  input  logic [N_SRC-1:0]           src_off_req,
  input  logic [N_DOM*CSC_SEL_W-1:0] dom_src_sel,
  input  logic [N_DOM*N_MOD-1:0]     mod_grant,
  input  logic                       cpu_idle,
  input  logic [N_BANK*2-1:0]        bank_mode,
  input  logic [1:0]                 pump_mode,
  output logic [N_DOM-1:0]           dom_clk_en,
  output logic [N_SRC-1:0]           src_en,
  output logic [N_BANK-1:0]          bank_sleep,
  output logic                       pump_sleep
);
  localparam int unsigned GRANT_W = N_DOM * N_MOD;

  logic [GRANT_W-1:0] grant_s;
  logic               idle_s;
  logic [N_DOM-1:0]   dom_en;

  csc_sync #(.W(GRANT_W)) u_grant_sync (
    .clk(clk), .rst_n(rst_n), .d_async(mod_grant), .q_sync(grant_s)
  );

  csc_sync #(.W(1)) u_idle_sync (
    .clk(clk), .rst_n(rst_n), .d_async(cpu_idle), .q_sync(idle_s)
  );

  genvar gd;
  generate
    for (gd = 0; gd < N_DOM; gd++) begin : g_dom
      csc_domain_gate #(.N_MOD(N_MOD), .IS_CPU(gd == 0)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .off_req  (dom_off_req[gd]),
        .grants_s (grant_s[gd*N_MOD +: N_MOD]),
        .idle_s   (idle_s),
        .en       (dom_en[gd])
      );
    end
  endgenerate

  csc_source_ctrl #(.N_SRC(N_SRC), .N_DOM(N_DOM), .SEL_W(CSC_SEL_W)) u_src (
    .clk         (clk),
    .rst_n       (rst_n),
    .dom_en      (dom_en),
    .dom_off_req (dom_off_req),
    .dom_src_sel (dom_src_sel),
    .src_off_req (src_off_req),
    .src_en      (src_en)
  );

  csc_flash_seq #(.N_BANK(N_BANK)) u_flash (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank_mode  (bank_mode),
    .pump_mode  (pump_mode),
    .bank_sleep (bank_sleep),
    .pump_sleep (pump_sleep)
  );

  assign dom_clk_en = dom_en;
endmodule

// File: rtl/clk_shutdown_ctrl_chk.sv
module clk_shutdown_ctrl_chk #(
  parameter int unsigned N_SRC  = 4,
  parameter int unsigned N_DOM  = 6,
  parameter int unsigned N_MOD  = 8,
  parameter int unsigned N_BANK = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_DOM-1:0]       dom_off_req,
  input logic [N_DOM*2-1:0]     dom_src_sel,
  input logic [N_DOM*N_MOD-1:0] grant_s,
  input logic                   idle_s,
  input logic [N_DOM-1:0]       dom_clk_en,
  input logic [N_SRC-1:0]       src_en,
  input logic [N_BANK-1:0]      bank_sleep,
  input logic                   pump_sleep
);
  logic [N_SRC-1:0] in_use;

  always_comb begin
    in_use = '0;
    for (int s = 0; s < N_SRC; s++)
      for (int d = 0; d < N_DOM; d++)
        if (dom_clk_en[d] && dom_src_sel[d*2 +: 2] == 2'(s)) in_use[s] = 1'b1;
  end

  genvar gd, gs;
  generate
    for (gd = 0; gd < N_DOM; gd++) begin : g_d
      p_gate_needs_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dom_clk_en[gd]) |-> ($past(&grant_s[gd*N_MOD +: N_MOD]) && $past(dom_off_req[gd])));
      p_reenable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !dom_off_req[gd] |=> dom_clk_en[gd]);
      p_stay_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dom_clk_en[gd] && dom_off_req[gd]) |=> !dom_clk_en[gd]);
    end
    for (gs = 0; gs < N_SRC; gs++) begin : g_s
      p_src_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_use[gs] |=> src_en[gs]);
    end
  endgenerate

  p_cpu_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dom_clk_en[0]) |-> $past(idle_s));

  p_pump_after_banks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pump_sleep |-> (&bank_sleep));
endmodule

bind clk_shutdown_ctrl clk_shutdown_ctrl_chk #(
  .N_SRC(N_SRC), .N_DOM(N_DOM), .N_MOD(N_MOD), .N_BANK(N_BANK)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dom_off_req (dom_off_req),
  .dom_src_sel (dom_src_sel),
  .grant_s     (grant_s),
  .idle_s      (idle_s),
  .dom_clk_en  (dom_clk_en),
  .src_en      (src_en),
  .bank_sleep  (bank_sleep),
  .pump_sleep  (pump_sleep)
);

// File: tb/clk_shutdown_ctrl_bench.sv
`timescale 1ns/1ps
module clk_shutdown_ctrl_bench;
  localparam int N_SRC = 4, N_DOM = 6, N_MOD = 8, N_BANK = 2;
  localparam int NV = 14;

  // {req6, srcoff4, grant48, idle1, sel12, bank4, pump2, exp_dom6, exp_src4, exp_bank2, exp_pump1}
  localparam logic [89:0] VEC [NV] = '{
    {6'h00,4'h0,48'h0000_0000_0000,1'b0,12'h4E4,4'hF,2'h3, 6'h3F,4'hF,2'h0,1'b0},
    {6'h3E,4'h0,48'h0000_0000_0000,1'b0,12'h4E4,4'hF,2'h3, 6'h3F,4'hF,2'h0,1'b0},
    {6'h3E,4'h0,48'h0000_0000_FF00,1'b0,12'h4E4,4'hF,2'h3, 6'h3D,4'hF,2'h0,1'b0},
    {6'h3E,4'h0,48'h0000_007F_FF00,1'b0,12'h4E4,4'hF,2'h3, 6'h3D,4'hF,2'h0,1'b0},
    {6'h3E,4'h0,48'h0000_0000_0000,1'b0,12'h4E4,4'hF,2'h3, 6'h3D,4'hF,2'h0,1'b0},
    {6'h3E,4'hF,48'h0000_0000_0000,1'b0,12'h4E4,4'hF,2'h3, 6'h3D,4'hF,2'h0,1'b0},
    {6'h3F,4'hF,48'hFFFF_FFFF_FFFF,1'b0,12'h4E4,4'hF,2'h3, 6'h01,4'h1,2'h0,1'b0},
    {6'h3F,4'hF,48'hFFFF_FFFF_FFFF,1'b1,12'h4E4,4'hF,2'h3, 6'h00,4'h0,2'h0,1'b0},
    {6'h37,4'hF,48'hFFFF_FFFF_FFFF,1'b1,12'h4E4,4'hF,2'h3, 6'h08,4'h8,2'h0,1'b0},
    {6'h37,4'hF,48'hFFFF_FFFF_FFFF,1'b1,12'h464,4'hF,2'h3, 6'h08,4'h2,2'h0,1'b0},
    {6'h37,4'hF,48'hFFFF_FFFF_FFFF,1'b1,12'h464,4'hC,2'h0, 6'h08,4'h2,2'h1,1'b0},
    {6'h37,4'hF,48'hFFFF_FFFF_FFFF,1'b1,12'h464,4'h0,2'h0, 6'h08,4'h2,2'h3,1'b1},
    {6'h37,4'hF,48'hFFFF_FFFF_FFFF,1'b1,12'h464,4'h0,2'h3, 6'h08,4'h2,2'h3,1'b0},
    {6'h37,4'hF,48'hFFFF_FFFF_FFFF,1'b1,12'h464,4'h4,2'h0, 6'h08,4'h2,2'h1,1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_DOM-1:0] dom_off_req = '0;
  logic [N_SRC-1:0] src_off_req = '0;
  logic [N_DOM*2-1:0] dom_src_sel = 12'h4E4;
  logic [N_DOM*N_MOD-1:0] mod_grant = '0;
  logic cpu_idle = 1'b0;
  logic [N_BANK*2-1:0] bank_mode = 4'hF;
  logic [1:0] pump_mode = 2'h3;
  logic [N_DOM-1:0] dom_clk_en;
  logic [N_SRC-1:0] src_en;
  logic [N_BANK-1:0] bank_sleep;
  logic pump_sleep;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  clk_shutdown_ctrl #(.N_SRC(N_SRC), .N_DOM(N_DOM), .N_MOD(N_MOD), .N_BANK(N_BANK)) u_clk_shutdown_ctrl (
    .clk(clk), .rst_n(rst_n), .dom_off_req(dom_off_req), .src_off_req(src_off_req),
    .dom_src_sel(dom_src_sel), .mod_grant(mod_grant), .cpu_idle(cpu_idle),
    .bank_mode(bank_mode), .pump_mode(pump_mode), .dom_clk_en(dom_clk_en),
    .src_en(src_en), .bank_sleep(bank_sleep), .pump_sleep(pump_sleep)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    step(3);
    // R8: reset state
    check("R8 dom in reset", 32'(dom_clk_en), 32'h3F);
    check("R8 src in reset", 32'(src_en), 32'hF);
    rst_n = 1'b1;
    step(1);
    check("R8 dom after reset", 32'(dom_clk_en), 32'h3F);
    check("R8 flash after reset", {29'd0, bank_sleep, pump_sleep}, 32'h0);

    // Vector walk: R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [89:0] v;
      v = VEC[i];
      dom_off_req = v[89:84];
      src_off_req = v[83:80];
      mod_grant   = v[79:32];
      cpu_idle    = v[31];
      dom_src_sel = v[30:19];
      bank_mode   = v[18:15];
      pump_mode   = v[14:13];
      step(8);
      check($sformatf("R1/R3/R7 vec%0d dom", i), 32'(dom_clk_en), 32'(v[12:7]));
      check($sformatf("R2/R6 vec%0d src", i), 32'(src_en), 32'(v[6:3]));
      check($sformatf("R5 vec%0d bank", i), 32'(bank_sleep), 32'(v[2:1]));
      check($sformatf("R4 vec%0d pump", i), 32'(pump_sleep), 32'(v[0]));
    end

    // Directed: reset again
    rst_n = 1'b0;
    dom_off_req = '0; src_off_req = '0; mod_grant = '0; cpu_idle = 1'b0;
    dom_src_sel = 12'h4E4; bank_mode = 4'hF; pump_mode = 2'h3;
    step(2);
    rst_n = 1'b1;
    step(2);
    check("R8 dom after re-reset", 32'(dom_clk_en), 32'h3F);

    // R9 latency and R2 source lag on domain 2 / source 2
    dom_off_req = 6'h04; src_off_req = 4'h4; mod_grant = 48'h0000_00FF_0000;
    step(2);
    check("R9 dom2 still on after two edges", 32'(dom_clk_en[2]), 32'h1);
    step(1);
    check("R9 dom2 off on third edge", 32'(dom_clk_en[2]), 32'h0);
    check("R2 src2 held while dom2 stops", 32'(src_en[2]), 32'h1);
    step(1);
    check("R2 src2 off one edge later", 32'(src_en[2]), 32'h0);

    // R7: grants withdrawn
    mod_grant = '0;
    step(5);
    check("R7 dom2 stays gated", 32'(dom_clk_en[2]), 32'h0);

    // R6: re-enable next edge, source forced on
    dom_off_req = '0;
    step(1);
    check("R6 dom2 back on next edge", 32'(dom_clk_en[2]), 32'h1);
    check("R6 src2 forced on", 32'(src_en[2]), 32'h1);

    // R3: CPU domain waits for idle
    dom_off_req = 6'h01; mod_grant = 48'h0000_0000_00FF; cpu_idle = 1'b0;
    step(6);
    check("R3 cpu held without idle", 32'(dom_clk_en[0]), 32'h1);
    cpu_idle = 1'b1;
    step(2);
    check("R3 R9 cpu on two edges after idle", 32'(dom_clk_en[0]), 32'h1);
    step(1);
    check("R3 cpu off third edge after idle", 32'(dom_clk_en[0]), 32'h0);

    // R4: pump wakes on the same edge a bank wakes
    bank_mode = 4'h0; pump_mode = 2'h0;
    step(4);
    check("R4 pump asleep with all banks", 32'(pump_sleep), 32'h1);
    bank_mode = 4'h3;
    step(1);
    check("R5 bank0 awake", 32'(bank_sleep), 32'h2);
    check("R4 pump wakes with bank", 32'(pump_sleep), 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule